// File: doc/BRIEF.md
# Precision ADC Conversion and Readout Sequencer

This block drives an 18-bit successive-approximation converter that has a serial output. For each sample it raises a conversion strobe. It waits out the conversion window and the quiet windows around that strobe. It then generates a serial clock and shifts the result in, most significant bit first. The finished sample appears on a parallel port together with a one-cycle valid pulse. Every delay is set in nanoseconds by a parameter and converted to system clock cycles with rounding up, so the real time of each window is never below its minimum.

Two cadences are supported, and the mode is chosen per conversion. In turbo mode the strobe is held high for the whole first quiet window. Readout starts as soon as that window has passed, while the converter is still working, so the word read belongs to the previous conversion. In plain chip-select mode the strobe is a short pulse and readout waits for the full conversion time, so the word read belongs to the current conversion. Holding the enable input high makes the block free-run at its fastest legal rate. A pulse on the start input asks for one conversion.

Top module: `adc_seq_top`

## Requirements
- R1: While reset is high, and after it has been released with no trigger, the strobe, the serial clock and the valid pulse are low. A reset in the middle of a readout returns all three to low.
- R2: Each sample is 18 bits. The first bit shifted in lands in bit 17 of the word and the last bit shifted in lands in bit 0.
- R3: Once high, the strobe stays high for at least 200 ns in turbo mode and for at least 10 ns in plain mode.
- R4: The first serial-clock rising edge comes at least 200 ns after the strobe rising edge in turbo mode, and at least 350 ns after it in plain mode.
- R5: The serial clock is low outside readout and never toggles while the strobe is high. During readout its high and low times are each at least half the 20 ns minimum period. It gives exactly 18 rising edges per conversion.
- R6: The data input is sampled on the serial-clock rising edge, after the converter has updated it following the previous falling edge.
- R7: At least 60 ns pass between the last serial-clock falling edge and the next strobe rising edge.
- R8: Strobe rising edges are at least 555 ns apart.
- R9: The valid output is high for exactly one cycle per sample. The sample word holds its value until the next valid pulse.
- R10: While enable is high, conversions follow one another with no further input.
- R11: With enable low, a one-cycle start pulse gives exactly one conversion. A start pulse that arrives during a conversion is remembered and served once that conversion has finished.
- R12: The mode input is taken at the strobe rising edge. Changing it later has no effect on that conversion's strobe width or readout timing.
- R13: With enable low and no start pulse, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Free-running conversions while high |
| start_i | input | 1 | One-cycle request for one conversion |
| turbo_i | input | 1 | 1 = turbo cadence, 0 = plain chip-select cadence |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Generated serial clock |
| sample_o | output | 18 | Last complete sample |
| sample_valid_o | output | 1 | One-cycle pulse when sample_o updates |

## Verification
The hardest case to reach is a start request that arrives while a conversion is still running, and in particular a mode change after the strobe has risen. Only then would a design that reads the mode input live, instead of the copy taken at launch, shorten the strobe or read the wrong word. The bench pulses start a few cycles into a conversion and flips the mode input at the same moment. A behavioural converter model returns the previous result in turbo mode and the current result in plain mode, so a readout taken at the wrong time shows up as a wrong word. The model also times every strobe and serial-clock edge in nanoseconds against the minimum windows.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    // Phases of one conversion and readout
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STROBE,
        PH_WAIT,
        PH_SHIFT,
        PH_GAP
    } phase_e;

    // Serial clock state plus the edges it will make at the next system edge
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sck_evt_t;

    // Picoseconds to whole clock cycles, rounded up, never below one
    function automatic int cyc_ceil(input int ps, input int period_ps);
        int c;
        c = (ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_sck.sv
`timescale 1ns/1ps
module adc_seq_sck
    import adc_seq_pkg::*;
#(
    parameter int HALF = 1
)(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_i,
    output sck_evt_t evt_o
);
    localparam int PH_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [PH_W-1:0] ph_q;
    logic            lvl_q;
    logic            turn;

    assign turn = run_i && (ph_q == PH_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            ph_q  <= '0;
            lvl_q <= 1'b0;
        end else if (turn) begin
            ph_q  <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    assign evt_o.level = lvl_q;
    assign evt_o.rise  = turn && !lvl_q;
    assign evt_o.fall  = turn && lvl_q;

    // The clock settles low whenever readout is not running
    assert_sclk_parks_low_R5: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !evt_o.level);

endmodule

// File: rtl/adc_seq_rx.sv
`timescale 1ns/1ps
module adc_seq_rx #(
    parameter int DATA_W = 18
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] word_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  n_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sh_q <= '0;
            n_q  <= '0;
        end else if (capture_i) begin
            sh_q <= {sh_q[DATA_W-2:0], sdo_i};
            n_q  <= n_q + 1'b1;
        end
    end

    assign word_o = sh_q;
    assign full_o = (n_q == CNT_W'(DATA_W));

    // Never more captures than bits in a word
    assert_no_extra_bit_R2: assert property (@(posedge clk) disable iff (rst)
        capture_i |-> !full_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int HIGH_T = 20,
    parameter int HIGH_P = 1,
    parameter int WAIT_T = 18,
    parameter int WAIT_P = 33,
    parameter int GAP_C  = 6,
    parameter int CYC_C  = 56,
    parameter int AGE_MX = 56
)(
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic start_i,
    input  logic turbo_i,
    input  logic sck_rise_i,
    input  logic sck_fall_i,
    input  logic rx_full_i,
    output logic conv_o,
    output logic sck_run_o,
    output logic rx_clear_o,
    output logic done_o
);
    localparam int AGE_W = $clog2(AGE_MX + 1);
    localparam int GAP_W = $clog2(GAP_C + 1);

    phase_e           ph_q, ph_n;
    logic [AGE_W-1:0] age_q;
    logic [GAP_W-1:0] gap_q;
    logic             pend_q, mode_q, conv_q;
    logic             launch;
    logic [AGE_W-1:0] hi_last, wait_th;

    assign launch  = (ph_q == PH_IDLE) && (enable_i || pend_q)
                     && (age_q >= AGE_W'(CYC_C - 1));
    assign hi_last = mode_q ? AGE_W'(HIGH_T - 1) : AGE_W'(HIGH_P - 1);
    assign wait_th = mode_q ? AGE_W'(WAIT_T) : AGE_W'(WAIT_P);

    always_comb begin
        ph_n = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (launch)                  ph_n = PH_STROBE;
            PH_STROBE: if (age_q == hi_last)        ph_n = PH_WAIT;
            PH_WAIT:   if (age_q >= wait_th)        ph_n = PH_SHIFT;
            PH_SHIFT:  if (sck_fall_i && rx_full_i) ph_n = PH_GAP;
            PH_GAP:    if (gap_q == GAP_W'(GAP_C - 1)) ph_n = PH_IDLE;
            default:                                ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            age_q  <= AGE_W'(AGE_MX);
            gap_q  <= '0;
            pend_q <= 1'b0;
            mode_q <= 1'b0;
            conv_q <= 1'b0;
        end else begin
            ph_q   <= ph_n;
            conv_q <= (ph_n == PH_STROBE);
            pend_q <= (pend_q || start_i) && !launch;
            if (launch) begin
                age_q  <= '0;
                mode_q <= turbo_i;
            end else if (age_q != AGE_W'(AGE_MX)) begin
                age_q  <= age_q + 1'b1;
            end
            gap_q <= (ph_q == PH_GAP) ? gap_q + 1'b1 : '0;
        end
    end

    assign conv_o     = conv_q;
    assign sck_run_o  = (ph_q == PH_SHIFT);
    assign rx_clear_o = launch;
    assign done_o     = (ph_q == PH_SHIFT) && (ph_n == PH_GAP);

    // Strobe width matches the mode taken at launch
    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(conv_q) |-> (age_q == hi_last + 1'b1));

    // No serial clock activity while the strobe is high
    assert_no_clock_in_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_STROBE) |-> (!sck_rise_i && !sck_fall_i));

endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int CLK_PS    = 10000,
    parameter int DATA_W    = 18,
    parameter int CONV_NS   = 350,
    parameter int QUIET1_NS = 200,
    parameter int QUIET2_NS = 60,
    parameter int CYCLE_NS  = 555,
    parameter int CNVH_NS   = 10,
    parameter int SCK_NS    = 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              start_i,
    input  logic              turbo_i,
    input  logic              sdo_i,
    output logic              conv_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_valid_o
);
    localparam int CONV_C = cyc_ceil(CONV_NS * 1000, CLK_PS);
    localparam int Q1_C   = cyc_ceil(QUIET1_NS * 1000, CLK_PS);
    localparam int Q2_C   = cyc_ceil(QUIET2_NS * 1000, CLK_PS);
    localparam int CYC_C  = cyc_ceil(CYCLE_NS * 1000, CLK_PS);
    localparam int CNVH_C = cyc_ceil(CNVH_NS * 1000, CLK_PS);
    localparam int HALF_C = cyc_ceil(SCK_NS * 500, CLK_PS);
    localparam int WAIT_T = imax(Q1_C - HALF_C - 1, 0);
    localparam int WAIT_P = imax(imax(CONV_C, Q1_C) - HALF_C - 1, 0);
    localparam int AGE_MX = imax(CYC_C, imax(CONV_C, Q1_C));

    sck_evt_t          sck;
    logic              run, clr, done, full;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] sample_q;
    logic              valid_q;

    adc_seq_ctrl #(
        .HIGH_T (Q1_C),
        .HIGH_P (CNVH_C),
        .WAIT_T (WAIT_T),
        .WAIT_P (WAIT_P),
        .GAP_C  (Q2_C),
        .CYC_C  (CYC_C),
        .AGE_MX (AGE_MX)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (enable_i),
        .start_i    (start_i),
        .turbo_i    (turbo_i),
        .sck_rise_i (sck.rise),
        .sck_fall_i (sck.fall),
        .rx_full_i  (full),
        .conv_o     (conv_o),
        .sck_run_o  (run),
        .rx_clear_o (clr),
        .done_o     (done)
    );

    adc_seq_sck #(.HALF(HALF_C)) u_sck (
        .clk   (clk),
        .rst   (rst),
        .run_i (run),
        .evt_o (sck)
    );

    adc_seq_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (clr),
        .capture_i (sck.rise),
        .sdo_i     (sdo_i),
        .word_o    (word),
        .full_o    (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= done;
            if (done) sample_q <= word;
        end
    end

    assign sclk_o         = sck.level;
    assign sample_o       = sample_q;
    assign sample_valid_o = valid_q;

    // Independent edge-distance counters for the timing windows
    localparam int CHK_MX = imax(CYC_C, imax(Q1_C, Q2_C)) + 1;
    localparam int CHK_W  = $clog2(CHK_MX + 1);

    logic [CHK_W-1:0] since_rise, since_fall;
    logic             conv_d, sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rise <= CHK_W'(CHK_MX);
            since_fall <= CHK_W'(CHK_MX);
            conv_d     <= 1'b0;
            sclk_d     <= 1'b0;
        end else begin
            conv_d <= conv_o;
            sclk_d <= sclk_o;
            if (conv_o && !conv_d)                since_rise <= CHK_W'(1);
            else if (since_rise != CHK_W'(CHK_MX)) since_rise <= since_rise + 1'b1;
            if (!sclk_o && sclk_d)                since_fall <= CHK_W'(1);
            else if (since_fall != CHK_W'(CHK_MX)) since_fall <= since_fall + 1'b1;
        end
    end

    assert_strobe_spacing_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> (since_rise >= CHK_W'(CYC_C)));

    assert_quiet_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_o) |-> (since_fall >= CHK_W'(Q2_C)));

    assert_quiet_before_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> (since_rise >= CHK_W'(Q1_C)));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |=> !sample_valid_o);

endmodule

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic        start_i = 1'b0;
    logic        turbo_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        conv_o, sclk_o, sample_valid_o;
    logic [17:0] sample_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk            (clk),
        .rst            (rst),
        .enable_i       (enable_i),
        .start_i        (start_i),
        .turbo_i        (turbo_i),
        .sdo_i          (sdo_i),
        .conv_o         (conv_o),
        .sclk_o         (sclk_o),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o)
    );

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_min(input string tag, input real act, input real lim);
        n_cmp++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s actual=%0.1f expected>=%0.1f", tag, act, lim);
        end
    endtask

    // Behavioural converter model
    logic [17:0] model_next = '0;
    logic [17:0] model_latched = '0;
    logic [17:0] shreg = '0;
    logic [17:0] latch_val;
    real t_rise = -1000.0, t_sck_fall = -1000.0, t_sck_rise = -1000.0;
    int  sck_rises = 0;
    int  conv_cnt = 0;
    logic cur_turbo = 1'b0;

    always @(posedge conv_o) begin
        chk_min("R8 strobe spacing ns", $realtime - t_rise, 555.0);
        chk_min("R7 quiet after readout ns", $realtime - t_sck_fall, 60.0);
        t_rise    = $realtime;
        cur_turbo = turbo_i;
        sck_rises = 0;
        conv_cnt++;
        latch_val = model_next;
        #340;
        model_latched = latch_val;
        if (sck_rises == 0 && !conv_o) begin
            shreg = model_latched;
            #3 sdo_i = shreg[17];
        end
    end

    always @(negedge conv_o) begin
        if (!rst) chk_min("R3 strobe width ns", $realtime - t_rise, cur_turbo ? 200.0 : 10.0);
        shreg = model_latched;
        #3 sdo_i = shreg[17];
    end

    always @(posedge sclk_o) begin
        if (sck_rises == 0)
            chk_min("R4 strobe to first clock ns", $realtime - t_rise, cur_turbo ? 200.0 : 350.0);
        else
            chk_min("R5 clock low time ns", $realtime - t_sck_fall, 10.0);
        chk_eq("R5 clock during strobe", conv_o, 1'b0);
        sck_rises++;
        t_sck_rise = $realtime;
    end

    always @(negedge sclk_o) begin
        chk_min("R5 clock high time ns", $realtime - t_sck_rise, 10.0);
        t_sck_fall = $realtime;
        shreg = shreg << 1;
        #3 sdo_i = shreg[17];
    end

    // Stimulus table: {turbo, pattern}
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 18'h3FFFF}, {1'b0, 18'h00000}, {1'b1, 18'h2AAAA}, {1'b1, 18'h15555},
        {1'b0, 18'h20001}, {1'b1, 18'h1E0F1}, {1'b1, 18'h00001}, {1'b0, 18'h12345}
    };

    logic [17:0] bench_latched = '0;

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_valid(output logic [17:0] w, output bit got);
        got = 1'b0;
        w   = '0;
        for (int c = 0; c < 400 && !got; c++) begin
            @(negedge clk);
            if (sample_valid_o) begin
                w   = sample_o;
                got = 1'b1;
            end
        end
    endtask

    bit done_flag = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] w;
        bit          got;
        int          c0;

        // R1: reset state
        repeat (5) @(negedge clk);
        chk_eq("R1 strobe in reset", conv_o, 1'b0);
        chk_eq("R1 clock in reset", sclk_o, 1'b0);
        chk_eq("R1 valid in reset", sample_valid_o, 1'b0);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        chk_eq("R1 R13 no strobe after reset", conv_cnt, 0);
        chk_eq("R1 valid idle", sample_valid_o, 1'b0);

        // Vector walk: R2, R6, R11, R5 bit count
        for (int i = 0; i < 8; i++) begin
            logic [17:0] expw;
            model_next = VEC[i][17:0];
            turbo_i    = VEC[i][18];
            expw       = VEC[i][18] ? bench_latched : VEC[i][17:0];
            c0         = conv_cnt;
            pulse_start();
            wait_valid(w, got);
            chk_eq("R11 single shot produced word", got, 1'b1);
            chk_eq("R2 R6 word msb first", w, expw);
            chk_eq("R5 eighteen clock rises", sck_rises, 18);
            @(negedge clk);
            chk_eq("R9 valid one cycle", sample_valid_o, 1'b0);
            bench_latched = VEC[i][17:0];
            repeat (80) @(negedge clk);
            chk_eq("R11 exactly one conversion", conv_cnt - c0, 1);
            chk_eq("R9 word held", sample_o, w);
        end

        // R13: no trigger, nothing happens
        c0 = conv_cnt;
        repeat (300) @(negedge clk);
        chk_eq("R13 idle without trigger", conv_cnt - c0, 0);
        chk_eq("R13 clock idle", sclk_o, 1'b0);

        // R10: free running turbo
        model_next = 18'h0F0F0;
        turbo_i    = 1'b1;
        enable_i   = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_valid(w, got);
            if (k == 3) enable_i = 1'b0;
            chk_eq("R10 free run word arrives", got, 1'b1);
            chk_eq("R10 free run word", w, (k == 0) ? bench_latched : 18'h0F0F0);
        end
        bench_latched = 18'h0F0F0;
        c0 = conv_cnt;
        repeat (200) @(negedge clk);
        chk_eq("R10 stops when enable drops", conv_cnt - c0, 0);

        // R11: start during busy conversion is remembered
        turbo_i    = 1'b0;
        model_next = 18'h0A5A5;
        c0         = conv_cnt;
        pulse_start();
        repeat (10) @(negedge clk);
        model_next = 18'h35A3C;
        pulse_start();
        wait_valid(w, got);
        chk_eq("R11 first of queued pair", w, 18'h0A5A5);
        wait_valid(w, got);
        chk_eq("R11 second of queued pair", w, 18'h35A3C);
        bench_latched = 18'h35A3C;
        repeat (100) @(negedge clk);
        chk_eq("R11 two conversions", conv_cnt - c0, 2);

        // R12: mode flips after launch
        turbo_i    = 1'b1;
        model_next = 18'h11111;
        pulse_start();
        repeat (3) @(negedge clk);
        turbo_i = 1'b0;
        wait_valid(w, got);
        chk_eq("R12 mode taken at launch", w, bench_latched);
        bench_latched = 18'h11111;
        repeat (100) @(negedge clk);

        // R1: reset in the middle of readout
        turbo_i    = 1'b0;
        model_next = 18'h2F00D;
        pulse_start();
        repeat (45) @(negedge clk);
        rst = 1'b1;
        repeat (10) @(negedge clk);
        chk_eq("R1 strobe after mid reset", conv_o, 1'b0);
        chk_eq("R1 clock after mid reset", sclk_o, 1'b0);
        chk_eq("R1 valid after mid reset", sample_valid_o, 1'b0);
        rst = 1'b0;
        bench_latched = 18'h2F00D;
        c0 = conv_cnt;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (sample_valid_o) chk_eq("R1 no valid after mid reset", sample_valid_o, 1'b0);
        end
        chk_eq("R1 R13 no restart after reset", conv_cnt - c0, 0);

        // One more plain conversion after reset recovers cleanly
        model_next = 18'h1C3C3;
        pulse_start();
        wait_valid(w, got);
        chk_eq("R2 word after reset recovery", w, 18'h1C3C3);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule